// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit core and a 32-bit word-addressed data memory. It has no state: every output depends only on the inputs of the same cycle. The store side takes an access operation, the low two address bits and the register value. It returns four byte-lane write enables and the write word, with the source bytes moved or copied into the lanes they belong in. The load side takes an access operation, the low two address bits, a signedness flag, the memory word and the old contents of the destination register. It returns the value to write back to the register.

Bytes are numbered little-endian, so offset 0 is data bits 7:0. Beside plain byte, halfword and word accesses, both sides also handle partial-word left and right forms at any offset. These forms merge the transferred bytes with the bytes already in the register (loads) or already in memory (stores, through the enables). A halfword or word access at an offset its size does not allow is flagged and has no effect. Address generation and the memory itself are outside the block.

The load and store sides are independent and may both be active in the same cycle. This allows a store request to go out while an earlier load's data returns.

Top module: `lsalign_unit`

## Requirements
- R1: Load byte (ldOp=1) returns the byte at lane ldOfs in bits 7:0. The upper 24 bits are copies of that byte's bit 7 when ldSigned=1, and zero when ldSigned=0.
- R2: Load halfword (ldOp=2) with ldOfs[0]=0 returns the 16 bits at lanes 1:0 (ldOfs[1]=0) or lanes 3:2 (ldOfs[1]=1) in bits 15:0. The upper 16 bits are filled with the halfword's bit 15 when ldSigned=1, and with zero otherwise.
- R3: Load word (ldOp=3) at ldOfs=0 returns memRdata unchanged, whatever ldSigned is.
- R4: Store byte (stOp=1) raises exactly the one write enable memWe[stOfs]. memWdata carries stData[7:0] in all four lanes.
- R5: Store halfword (stOp=2) with stOfs[0]=0 raises memWe=4'b0011 (stOfs[1]=0) or 4'b1100 (stOfs[1]=1), with stData[15:0] in both halves of memWdata. Store word (stOp=3) at stOfs=0 raises 4'b1111 with memWdata=stData.
- R6: Load left (ldOp=4) at offset a writes memory lanes 0..a into register lanes 3-a..3, in order. Register lanes below 3-a keep their regOld value.
- R7: Load right (ldOp=5) at offset a writes memory lanes a..3 into register lanes 0..3-a, in order. Register lanes above 3-a keep their regOld value.
- R8: Store left (stOp=4) at offset a enables lanes 0..a and puts register lanes 3-a..3 there. Store right (stOp=5) at offset a enables lanes a..3 and puts register lanes 0..3-a there.
- R9: A halfword access with an odd offset, or a word access with a nonzero offset, raises the side's misaligned output. A flagged store has memWe=0, and a flagged load returns regOld.
- R10: Operation codes 0, 6 and 7 are idle: memWe=0, ldResult=regOld, and neither misaligned output is raised.
- R11: The load and store sides act independently. Any operation on one side gives the same outputs as it would with the other side idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ldOp | input | 3 | Load operation: 0 idle, 1 byte, 2 halfword, 3 word, 4 left, 5 right, 6/7 idle |
| ldOfs | input | 2 | Low address bits of the load |
| ldSigned | input | 1 | 1 = sign-extend byte/halfword loads, 0 = zero-extend |
| memRdata | input | 32 | Word read from data memory |
| regOld | input | 32 | Current contents of the destination register |
| ldResult | output | 32 | Value to write back to the destination register |
| ldMisaligned | output | 1 | Load offset not allowed for its size |
| stOp | input | 3 | Store operation, same encoding as ldOp |
| stOfs | input | 2 | Low address bits of the store |
| stData | input | 32 | Register value to be stored |
| memWe | output | 4 | Byte-lane write enables, bit i = bits 8i+7:8i |
| memWdata | output | 32 | Write word, lanes aligned to memWe |
| stMisaligned | output | 1 | Store offset not allowed for its size |

## Verification
A load return and a store request can fall in the same cycle, because the two sides share no input. The bench drives both sides at once with differing operations and offsets, for example a load-left merge while a misaligned store is suppressed. It judges each side against the value its reference model gives for that side alone. A side effect from one path into the other therefore shows up as a mismatch on the quiet side's outputs.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFS_W  = $clog2(LANES);
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_NONE  = 3'd0;
  localparam logic [OP_W-1:0] OP_BYTE  = 3'd1;
  localparam logic [OP_W-1:0] OP_HALF  = 3'd2;
  localparam logic [OP_W-1:0] OP_WORD  = 3'd3;
  localparam logic [OP_W-1:0] OP_LEFT  = 3'd4;
  localparam logic [OP_W-1:0] OP_RIGHT = 3'd5;

  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_BYTE = 2'd1,
    FILL_HALF = 2'd2
  } fill_e;

  // load-side strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] laneSel;     // 1 = lane taken from shifted memory word
    logic             shiftRight;
    logic [OFS_W-1:0] shamt;       // in lanes
    fill_e            fill;        // extension width
    logic             signExt;
  } ldStrobe_t;

  // store-side strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] we;
    logic             shiftRight;
    logic [OFS_W-1:0] shamt;
    fill_e            repl;        // replication of low byte / halfword
  } stStrobe_t;
endpackage

// File: rtl/lsalign_ctrl.sv
module lsalign_ctrl
  import lsalign_pkg::*;
(
  input  logic [OP_W-1:0]  ldOp,
  input  logic [OFS_W-1:0] ldOfs,
  input  logic             ldSigned,
  input  logic [OP_W-1:0]  stOp,
  input  logic [OFS_W-1:0] stOfs,
  output ldStrobe_t        ldStb,
  output stStrobe_t        stStb,
  output logic             ldMisaligned,
  output logic             stMisaligned
);
  localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};
  localparam logic [OFS_W-1:0] TOP_LANE  = OFS_W'(LANES - 1);
  localparam logic [LANES-1:0] LOW_PAIR  = LANES'(2'b11);
  localparam logic [LANES-1:0] HIGH_PAIR = LANES'(2'b11) << 2;

  // load decode
  always_comb begin
    ldStb        = '{laneSel: '0, shiftRight: 1'b1, shamt: '0,
                     fill: FILL_NONE, signExt: 1'b0};
    ldMisaligned = 1'b0;
    case (ldOp)
      OP_BYTE: begin
        ldStb.shamt   = ldOfs;
        ldStb.laneSel = LANES'(1);
        ldStb.fill    = FILL_BYTE;
        ldStb.signExt = ldSigned;
      end
      OP_HALF: begin
        if (ldOfs[0]) ldMisaligned = 1'b1;
        else begin
          ldStb.shamt   = ldOfs;
          ldStb.laneSel = LOW_PAIR;
          ldStb.fill    = FILL_HALF;
          ldStb.signExt = ldSigned;
        end
      end
      OP_WORD: begin
        if (ldOfs != '0) ldMisaligned = 1'b1;
        else             ldStb.laneSel = ALL_LANES;
      end
      OP_LEFT: begin
        ldStb.shiftRight = 1'b0;
        ldStb.shamt      = TOP_LANE - ldOfs;
        ldStb.laneSel    = ALL_LANES << (TOP_LANE - ldOfs);
      end
      OP_RIGHT: begin
        ldStb.shamt   = ldOfs;
        ldStb.laneSel = ALL_LANES >> ldOfs;
      end
      default: ;
    endcase
  end

  // store decode
  always_comb begin
    stStb        = '{we: '0, shiftRight: 1'b0, shamt: '0, repl: FILL_NONE};
    stMisaligned = 1'b0;
    case (stOp)
      OP_BYTE: begin
        stStb.we   = LANES'(1) << stOfs;
        stStb.repl = FILL_BYTE;
      end
      OP_HALF: begin
        if (stOfs[0]) stMisaligned = 1'b1;
        else begin
          stStb.we   = stOfs[1] ? HIGH_PAIR : LOW_PAIR;
          stStb.repl = FILL_HALF;
        end
      end
      OP_WORD: begin
        if (stOfs != '0) stMisaligned = 1'b1;
        else             stStb.we = ALL_LANES;
      end
      OP_LEFT: begin
        stStb.shiftRight = 1'b1;
        stStb.shamt      = TOP_LANE - stOfs;
        stStb.we         = ALL_LANES >> (TOP_LANE - stOfs);
      end
      OP_RIGHT: begin
        stStb.shamt = stOfs;
        stStb.we    = ALL_LANES << stOfs;
      end
      default: ;
    endcase
  end

  always_comb begin
    // R9
    misWe_chk: assert (!stMisaligned || stStb.we == '0)
      else $error("misaligned store kept a write enable");
    // R4
    byteOneLane_chk: assert (stOp != OP_BYTE || $countones(stStb.we) == 1)
      else $error("byte store enable count wrong");
    // R5
    halfPair_chk: assert (stOp != OP_HALF || stMisaligned ||
                          stStb.we == LOW_PAIR || stStb.we == HIGH_PAIR)
      else $error("halfword store enables not a lane pair");
    // R6
    leftCount_chk: assert (ldOp != OP_LEFT ||
                           ($countones(ldStb.laneSel) == int'(ldOfs) + 1 &&
                            ldStb.laneSel[LANES-1]))
      else $error("load-left lane selection wrong");
    // R8
    rightTop_chk: assert (stOp != OP_RIGHT ||
                          ($countones(stStb.we) == LANES - int'(stOfs) &&
                           stStb.we[LANES-1]))
      else $error("store-right enables wrong");
    // R10
    idle_chk: assert (!(stOp == OP_NONE || stOp > OP_RIGHT) ||
                      (stStb.we == '0 && !stMisaligned))
      else $error("idle store had an effect");
  end
endmodule

// File: rtl/lsalign_dp.sv
module lsalign_dp
  import lsalign_pkg::*;
(
  input  ldStrobe_t          ldStb,
  input  stStrobe_t          stStb,
  input  logic [WORD_W-1:0]  memRdata,
  input  logic [WORD_W-1:0]  regOld,
  input  logic [WORD_W-1:0]  stData,
  output logic [WORD_W-1:0]  ldResult,
  output logic [WORD_W-1:0]  memWdata
);
  localparam int SH_W = OFS_W + $clog2(LANE_W);

  logic [WORD_W-1:0] ldShifted;
  logic [SH_W-1:0]   ldBits;
  logic              signBit;
  logic [LANE_W-1:0] fillByte;

  assign ldBits    = {ldStb.shamt, {($clog2(LANE_W)){1'b0}}};
  assign ldShifted = ldStb.shiftRight ? (memRdata >> ldBits) : (memRdata << ldBits);
  assign signBit   = (ldStb.fill == FILL_HALF) ? ldShifted[2*LANE_W-1] : ldShifted[LANE_W-1];
  assign fillByte  = {LANE_W{ldStb.signExt & signBit}};

  for (genvar i = 0; i < LANES; i++) begin : g_ldLane
    logic fillLane;
    assign fillLane = (ldStb.fill == FILL_BYTE && i >= 1) ||
                      (ldStb.fill == FILL_HALF && i >= 2);
    always_comb begin
      if (ldStb.laneSel[i])  ldResult[i*LANE_W +: LANE_W] = ldShifted[i*LANE_W +: LANE_W];
      else if (fillLane)     ldResult[i*LANE_W +: LANE_W] = fillByte;
      else                   ldResult[i*LANE_W +: LANE_W] = regOld[i*LANE_W +: LANE_W];
    end
  end

  logic [WORD_W-1:0] stBase;
  logic [SH_W-1:0]   stBits;

  always_comb begin
    case (stStb.repl)
      FILL_BYTE: stBase = {LANES{stData[LANE_W-1:0]}};
      FILL_HALF: stBase = {(LANES/2){stData[2*LANE_W-1:0]}};
      default:   stBase = stData;
    endcase
  end

  assign stBits   = {stStb.shamt, {($clog2(LANE_W)){1'b0}}};
  assign memWdata = stStb.shiftRight ? (stBase >> stBits) : (stBase << stBits);

  always_comb begin
    // R1
    zeroFill_chk: assert (!(ldStb.fill == FILL_BYTE && !ldStb.signExt) ||
                          ldResult[WORD_W-1:LANE_W] == '0)
      else $error("unsigned byte load has nonzero upper bits");
  end
endmodule

// File: rtl/lsalign_unit.sv
module lsalign_unit
  import lsalign_pkg::*;
(
  input  logic [2:0]  ldOp,
  input  logic [1:0]  ldOfs,
  input  logic        ldSigned,
  input  logic [31:0] memRdata,
  input  logic [31:0] regOld,
  output logic [31:0] ldResult,
  output logic        ldMisaligned,
  input  logic [2:0]  stOp,
  input  logic [1:0]  stOfs,
  input  logic [31:0] stData,
  output logic [3:0]  memWe,
  output logic [31:0] memWdata,
  output logic        stMisaligned
);
  ldStrobe_t ldStb;
  stStrobe_t stStb;

  lsalign_ctrl u_ctrl (
    .ldOp(ldOp), .ldOfs(ldOfs), .ldSigned(ldSigned),
    .stOp(stOp), .stOfs(stOfs),
    .ldStb(ldStb), .stStb(stStb),
    .ldMisaligned(ldMisaligned), .stMisaligned(stMisaligned)
  );

  lsalign_dp u_dp (
    .ldStb(ldStb), .stStb(stStb),
    .memRdata(memRdata), .regOld(regOld), .stData(stData),
    .ldResult(ldResult), .memWdata(memWdata)
  );

  assign memWe = stStb.we;
endmodule

// File: tb/lsalign_unit_bench.sv
module lsalign_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  ldOp = '0;
  logic [1:0]  ldOfs = '0;
  logic        ldSigned = 1'b0;
  logic [31:0] memRdata = '0;
  logic [31:0] regOld = '0;
  logic [31:0] ldResult;
  logic        ldMisaligned;
  logic [2:0]  stOp = '0;
  logic [1:0]  stOfs = '0;
  logic [31:0] stData = '0;
  logic [3:0]  memWe;
  logic [31:0] memWdata;
  logic        stMisaligned;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  lsalign_unit u_lsalign_unit (
    .ldOp(ldOp), .ldOfs(ldOfs), .ldSigned(ldSigned), .memRdata(memRdata),
    .regOld(regOld), .ldResult(ldResult), .ldMisaligned(ldMisaligned),
    .stOp(stOp), .stOfs(stOfs), .stData(stData), .memWe(memWe),
    .memWdata(memWdata), .stMisaligned(stMisaligned)
  );

  // reference: register value after a load, from the requirement text
  function automatic logic [32:0] refLoad(input logic [2:0] op, input int a,
      input logic sgn, input logic [31:0] mem, input logic [31:0] old);
    logic [31:0] r = old;
    logic mis = 1'b0;
    case (op)
      3'd1: begin
        r = {24'(0), mem[8*a +: 8]};
        if (sgn && mem[8*a+7]) r[31:8] = '1;
      end
      3'd2: if (a % 2 == 1) mis = 1'b1;
            else begin
              r = {16'(0), mem[16*(a/2) +: 16]};
              if (sgn && mem[16*(a/2)+15]) r[31:16] = '1;
            end
      3'd3: if (a != 0) mis = 1'b1; else r = mem;
      3'd4: for (int k = 0; k <= a; k++) r[8*(3-a+k) +: 8] = mem[8*k +: 8];
      3'd5: for (int k = a; k < 4; k++) r[8*(k-a) +: 8] = mem[8*k +: 8];
      default: ;
    endcase
    return {mis, r};
  endfunction

  // reference: {misaligned, enables, data} for a store
  function automatic logic [36:0] refStore(input logic [2:0] op, input int a,
      input logic [31:0] d);
    logic [3:0] we = '0;
    logic [31:0] wd = '0;
    logic mis = 1'b0;
    case (op)
      3'd1: begin we[a] = 1'b1; for (int k = 0; k < 4; k++) wd[8*k +: 8] = d[7:0]; end
      3'd2: if (a % 2 == 1) mis = 1'b1;
            else begin
              we = (a == 2) ? 4'b1100 : 4'b0011;
              wd = {d[15:0], d[15:0]};
            end
      3'd3: if (a != 0) mis = 1'b1; else begin we = 4'hF; wd = d; end
      3'd4: for (int k = 0; k <= a; k++) begin we[k] = 1'b1; wd[8*k +: 8] = d[8*(3-a+k) +: 8]; end
      3'd5: for (int k = a; k < 4; k++) begin we[k] = 1'b1; wd[8*k +: 8] = d[8*(k-a) +: 8]; end
      default: ;
    endcase
    return {mis, we, wd};
  endfunction

  function automatic logic [31:0] laneMask(input logic [3:0] we);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (we[k]) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic checkLoad(input string req);
    logic [32:0] exp = refLoad(ldOp, int'(ldOfs), ldSigned, memRdata, regOld);
    nChecks++;
    if ({ldMisaligned, ldResult} !== exp) begin
      nFails++;
      $display("FAIL %s: load op=%0d ofs=%0d sgn=%0b got mis=%0b res=%h exp mis=%0b res=%h",
               req, ldOp, ldOfs, ldSigned, ldMisaligned, ldResult, exp[32], exp[31:0]);
    end
  endtask

  task automatic checkStore(input string req);
    logic [36:0] exp = refStore(stOp, int'(stOfs), stData);
    logic [31:0] m = laneMask(exp[35:32]);
    nChecks++;
    if (stMisaligned !== exp[36] || memWe !== exp[35:32] ||
        (memWdata & m) !== (exp[31:0] & m)) begin
      nFails++;
      $display("FAIL %s: store op=%0d ofs=%0d got mis=%0b we=%b wd=%h exp mis=%0b we=%b wd=%h",
               req, stOp, stOfs, stMisaligned, memWe, memWdata & m, exp[36], exp[35:32], exp[31:0] & m);
    end
  endtask

  task automatic driveLd(input logic [2:0] op, input int a, input logic sgn,
                         input logic [31:0] mem, input logic [31:0] old);
    ldOp = op; ldOfs = a[1:0]; ldSigned = sgn; memRdata = mem; regOld = old;
  endtask

  task automatic driveSt(input logic [2:0] op, input int a, input logic [31:0] d);
    stOp = op; stOfs = a[1:0]; stData = d;
  endtask

  task automatic settle;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleBoth;
    driveLd(3'd0, 0, 1'b0, 32'h0, 32'h0);
    driveSt(3'd0, 0, 32'h0);
  endtask

  task automatic testIdle;  // R10
    for (int op = 0; op < 8; op += 6) begin
      for (int a = 0; a < 4; a++) begin
        driveLd(op[2:0], a, 1'b1, 32'hF00D_BEEF, 32'h1357_9BDF);
        driveSt(op[2:0], a, 32'hCAFE_0123);
        settle();
        checkLoad("R10");
        checkStore("R10");
      end
    end
    driveLd(3'd7, 1, 1'b0, 32'h1111_2222, 32'hAAAA_5555);
    driveSt(3'd7, 2, 32'h3333_4444);
    settle();
    checkLoad("R10");
    checkStore("R10");
    idleBoth();
  endtask

  task automatic testByteLoad;  // R1
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 2; s++) begin
        driveLd(3'd1, a, s[0], 32'h80_7F_C3_15, 32'hDEAD_BEEF);
        settle(); checkLoad("R1");
        driveLd(3'd1, a, s[0], 32'h01_F2_63_A4, 32'h0);
        settle(); checkLoad("R1");
      end
    idleBoth();
  endtask

  task automatic testHalfWordLoad;  // R2 R3
    for (int a = 0; a < 4; a += 2)
      for (int s = 0; s < 2; s++) begin
        driveLd(3'd2, a, s[0], 32'h8001_7FFE, 32'h5A5A_5A5A);
        settle(); checkLoad("R2");
        driveLd(3'd2, a, s[0], 32'h1234_9876, 32'h5A5A_5A5A);
        settle(); checkLoad("R2");
      end
    driveLd(3'd3, 0, 1'b1, 32'h89AB_CDEF, 32'h0);
    settle(); checkLoad("R3");
    driveLd(3'd3, 0, 1'b0, 32'h0123_4567, 32'hFFFF_FFFF);
    settle(); checkLoad("R3");
    idleBoth();
  endtask

  task automatic testAlignedStores;  // R4 R5
    for (int a = 0; a < 4; a++) begin
      driveSt(3'd1, a, 32'h1234_56A9);
      settle(); checkStore("R4");
    end
    for (int a = 0; a < 4; a += 2) begin
      driveSt(3'd2, a, 32'hFEDC_B0A1);
      settle(); checkStore("R5");
    end
    driveSt(3'd3, 0, 32'h7654_3210);
    settle(); checkStore("R5");
    idleBoth();
  endtask

  task automatic testLoadLeftRight;  // R6 R7
    for (int a = 0; a < 4; a++) begin
      driveLd(3'd4, a, 1'b1, 32'h4433_2211, 32'hDDCC_BBAA);
      settle(); checkLoad("R6");
      driveLd(3'd5, a, 1'b1, 32'h4433_2211, 32'hDDCC_BBAA);
      settle(); checkLoad("R7");
    end
    idleBoth();
  endtask

  task automatic testStoreLeftRight;  // R8
    for (int a = 0; a < 4; a++) begin
      driveSt(3'd4, a, 32'h8877_6655);
      settle(); checkStore("R8");
      driveSt(3'd5, a, 32'h8877_6655);
      settle(); checkStore("R8");
    end
    idleBoth();
  endtask

  task automatic testMisaligned;  // R9
    for (int a = 1; a < 4; a += 2) begin
      driveLd(3'd2, a, 1'b1, 32'hFFFF_FFFF, 32'h0BAD_F00D);
      driveSt(3'd2, a, 32'hFFFF_FFFF);
      settle(); checkLoad("R9"); checkStore("R9");
    end
    for (int a = 1; a < 4; a++) begin
      driveLd(3'd3, a, 1'b0, 32'h1234_5678, 32'hC0FF_EE00);
      driveSt(3'd3, a, 32'h1234_5678);
      settle(); checkLoad("R9"); checkStore("R9");
    end
    idleBoth();
  endtask

  task automatic testConcurrent;  // R11
    for (int a = 0; a < 4; a++) begin
      driveLd(3'd4, a, 1'b0, 32'hA1B2_C3D4, 32'h1020_3040);
      driveSt(3'd3, 3 - a, 32'h5566_7788);
      settle(); checkLoad("R11"); checkStore("R11");
      driveLd(3'd1, 3 - a, 1'b1, 32'h80FF_7F01, 32'h0);
      driveSt(3'd5, a, 32'hDEAD_C0DE);
      settle(); checkLoad("R11"); checkStore("R11");
    end
    idleBoth();
  endtask

  initial begin
    idleBoth();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle state after reset release: R10
    checkLoad("R10");
    checkStore("R10");
    testIdle();
    testByteLoad();
    testHalfWordLoad();
    testAlignedStores();
    testLoadLeftRight();
    testStoreLeftRight();
    testMisaligned();
    testConcurrent();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule